// File: doc/BRIEF.md
# Multichannel Serial Audio Transmitter

The transmitter drives four serial audio data lanes. All lanes share one bit clock and one left/right word clock. The bit clock comes from dividing one of two master clock sources. Each master clock reaches the block as a tick stream that is already qualified in the system clock domain, and a select input picks which stream feeds the divider. Every frame holds 64 bit clocks: a left slot with the word clock low, then a right slot with the word clock high. Each slot is 32 bits long and is sent MSB first.

Each lane holds a small queue of stereo sample pairs, filled through a valid/ready port. A lane starts at a left-slot boundary once it is enabled, and it stops at the frame boundary after it is disabled. A read-only running flag shows whether the lane is active. The sample width is 16, 20 or 24 bits. For 20 and 24 bits, the sample can sit at either end of the 32-bit slot. A buffer-reset pulse empties the queues of all lanes. An empty queue at a frame start gives a silent frame and sets a sticky underrun flag.

Top module: `aud_tx`

## Requirements
- R1: The bit-clock period, counted in selected master ticks, is 2, 4, 8 or 12 for divide codes 1, 2, 4 and 6. Every other code gives 2. Data and word clock change only on a falling bit-clock edge.
- R2: With `mck_sel_i` = 0 the divider counts `mck0_tick_i`. With `mck_sel_i` = 1 it counts `mck1_tick_i`.
- R3: A frame is 64 bit clocks. Bits 0..31 are the left slot with `wclk_o` = 0, and bits 32..63 are the right slot with `wclk_o` = 1. Each slot is sent bit 31 first.
- R4: Width code 0 (16 bits) and the reserved code 1 both place sample bits [15:0] in slot bits [31:16], with all other slot bits 0. The side bit is ignored for these codes.
- R5: Width code 2 uses sample bits [19:0] and width code 3 uses sample bits [23:0]. With `msb_side_i` = 0 the sample sits at slot bit 0 upward. With `msb_side_i` = 1 it ends at slot bit 31. Unused slot bits are 0.
- R6: All running lanes share frame boundaries. A lane that is enabled mid-frame starts at the next left-slot boundary and sends a complete first frame.
- R7: `run_o[n]` rises at the first frame boundary after `lane_en_i[n]` is set. It falls at the first frame boundary after `lane_en_i[n]` is cleared. While the flag is 0, `sdata_o[n]` is 0.
- R8: If a running lane's queue is empty at a frame start, the lane sends zeros in both slots and sets `underrun_o[n]`. The flag stays set until a buffer reset.
- R9: A one-cycle `buf_rst_i` pulse empties the queues of all lanes and clears every underrun flag. Pairs queued before the pulse are never sent.
- R10: A pair is accepted when `s_valid_i[n]` and `s_ready_o[n]` are both high. `s_ready_o[n]` is low when the queue holds `FIFO_DEPTH` pairs, and an offered pair is then dropped. Accepted pairs are sent one pair per frame, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mck0_tick_i | input | 1 | Master clock 0 tick stream |
| mck1_tick_i | input | 1 | Master clock 1 tick stream |
| mck_sel_i | input | 1 | Master clock select |
| div_code_i | input | 4 | Bit-clock divide code |
| width_code_i | input | 2 | Sample width code |
| msb_side_i | input | 1 | 1: sample at MSB end of slot |
| lane_en_i | input | NUM_LANES | Per-lane enable |
| buf_rst_i | input | 1 | Pulse: empty all queues |
| s_valid_i | input | NUM_LANES | Pair valid per lane |
| s_left_i | input | NUM_LANES*24 | Left samples, lane n at [24n+23:24n] |
| s_right_i | input | NUM_LANES*24 | Right samples, lane n at [24n+23:24n] |
| s_ready_o | output | NUM_LANES | Queue can accept a pair |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, low = left |
| sdata_o | output | NUM_LANES | Serial data per lane |
| run_o | output | NUM_LANES | Lane running flag |
| underrun_o | output | NUM_LANES | Sticky underrun flag |

## Verification
The assertions assume that the master tick streams, the divide code and the select input change only while the bit clock is free-running. They also assume that the width and side settings stay constant while any lane is running. The stimulus follows this: it changes the format only after every running flag has dropped, and it changes the divide code only while all lanes are idle. Random sample data and random enable timing are applied within these limits. A frame monitor rebuilds every frame from the bit clock and word clock and checks each captured frame against expected slot values computed from R4 and R5.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int SLOT_BITS  = 32;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int PAIR_W     = 2 * SAMPLE_W;
  localparam int DIV_W      = 4;

  // half bit-clock period in master ticks
  function automatic logic [DIV_W-1:0] half_ratio(input logic [3:0] code);
    case (code)
      4'd2:    return DIV_W'(2);
      4'd4:    return DIV_W'(4);
      4'd6:    return DIV_W'(6);
      default: return DIV_W'(1);
    endcase
  endfunction

  function automatic logic [SLOT_BITS-1:0] place_sample(input logic [1:0] wcode,
                                                         input logic msb,
                                                         input logic [SAMPLE_W-1:0] s);
    logic [SLOT_BITS-1:0] r;
    case (wcode)
      2'd2:    r = msb ? {s[19:0], 12'b0} : {12'b0, s[19:0]};
      2'd3:    r = msb ? {s[23:0], 8'b0}  : {8'b0, s[23:0]};
      default: r = {s[15:0], 16'b0};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen
  import aud_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mck0_tick_i,
  input  logic       mck1_tick_i,
  input  logic       mck_sel_i,
  input  logic [3:0] div_code_i,
  output logic       bclk_o,
  output logic       wclk_o,
  output logic       bit_stb_o,
  output logic       frame_stb_o
);
  localparam int BIT_CNT_W = $clog2(FRAME_BITS);

  logic                 tick;
  logic [DIV_W-1:0]     half, last, cnt_q, cnt_d;
  logic                 wrap, bclk_q;
  logic [BIT_CNT_W-1:0] bit_cnt_q;

  assign tick  = mck_sel_i ? mck1_tick_i : mck0_tick_i;
  assign half  = half_ratio(div_code_i);
  assign last  = (half << 1) - DIV_W'(1);
  // >= keeps the counter bounded if the code shrinks mid-period
  assign wrap  = (cnt_q >= last);
  assign cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      bclk_q <= (cnt_d >= half);
    end
  end

  assign bit_stb_o   = tick & wrap;
  assign frame_stb_o = bit_stb_o & (bit_cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bit_cnt_q <= '0;
    else if (bit_stb_o) bit_cnt_q <= bit_cnt_q + BIT_CNT_W'(1);
  end

  assign bclk_o = bclk_q;
  assign wclk_o = bit_cnt_q[BIT_CNT_W-1];

  // R1
  bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bclk_o);
  // R3
  wclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o |=> $stable(wclk_o));
endmodule

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int W     = 48,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         wr_valid_i,
  output logic         wr_ready_o,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             push, pop;

  assign wr_ready_o = (count_q != CNT_W'(DEPTH));
  assign empty_o    = (count_q == '0);
  assign push       = wr_valid_i & wr_ready_o & ~flush_i;
  assign pop        = rd_en_i & ~empty_o & ~flush_i;
  assign rd_data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  // R10
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/aud_tx_lane.sv
module aud_tx_lane
  import aud_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                bit_stb_i,
  input  logic                frame_stb_i,
  input  logic [1:0]          width_code_i,
  input  logic                msb_side_i,
  input  logic                buf_rst_i,
  input  logic                s_valid_i,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                s_ready_o,
  output logic                sdata_o,
  output logic                run_o,
  output logic                underrun_o
);
  logic [PAIR_W-1:0]     rd_pair;
  logic                  empty, pop;
  logic [FRAME_BITS-1:0] frame_q;
  logic                  run_q, underrun_q;

  aud_tx_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (buf_rst_i),
    .wr_valid_i (s_valid_i),
    .wr_ready_o (s_ready_o),
    .wr_data_i  ({s_left_i, s_right_i}),
    .rd_en_i    (pop),
    .rd_data_o  (rd_pair),
    .empty_o    (empty)
  );

  assign pop = frame_stb_i & en_i & ~empty & ~buf_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      run_q   <= 1'b0;
    end else if (frame_stb_i) begin
      run_q   <= en_i;
      frame_q <= pop ? {place_sample(width_code_i, msb_side_i, rd_pair[PAIR_W-1:SAMPLE_W]),
                        place_sample(width_code_i, msb_side_i, rd_pair[SAMPLE_W-1:0])}
                     : '0;
    end else if (bit_stb_i) begin
      frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         underrun_q <= 1'b0;
    else if (buf_rst_i)                  underrun_q <= 1'b0;
    else if (frame_stb_i & en_i & empty) underrun_q <= 1'b1;
  end

  assign sdata_o    = run_q & frame_q[FRAME_BITS-1];
  assign run_o      = run_q;
  assign underrun_o = underrun_q;

  // R7
  run_on_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(run_o));
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> !sdata_o);
  // R8
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !buf_rst_i) |=> underrun_o);
endmodule

// File: rtl/aud_tx.sv
module aud_tx
  import aud_tx_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          mck0_tick_i,
  input  logic                          mck1_tick_i,
  input  logic                          mck_sel_i,
  input  logic [3:0]                    div_code_i,
  input  logic [1:0]                    width_code_i,
  input  logic                          msb_side_i,
  input  logic [NUM_LANES-1:0]          lane_en_i,
  input  logic                          buf_rst_i,
  input  logic [NUM_LANES-1:0]          s_valid_i,
  input  logic [NUM_LANES*SAMPLE_W-1:0] s_left_i,
  input  logic [NUM_LANES*SAMPLE_W-1:0] s_right_i,
  output logic [NUM_LANES-1:0]          s_ready_o,
  output logic                          bclk_o,
  output logic                          wclk_o,
  output logic [NUM_LANES-1:0]          sdata_o,
  output logic [NUM_LANES-1:0]          run_o,
  output logic [NUM_LANES-1:0]          underrun_o
);
  logic bit_stb, frame_stb;

  aud_tx_clkgen u_clkgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mck0_tick_i (mck0_tick_i),
    .mck1_tick_i (mck1_tick_i),
    .mck_sel_i   (mck_sel_i),
    .div_code_i  (div_code_i),
    .bclk_o      (bclk_o),
    .wclk_o      (wclk_o),
    .bit_stb_o   (bit_stb),
    .frame_stb_o (frame_stb)
  );

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    aud_tx_lane #(.FIFO_DEPTH(FIFO_DEPTH)) u_lane (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (lane_en_i[n]),
      .bit_stb_i    (bit_stb),
      .frame_stb_i  (frame_stb),
      .width_code_i (width_code_i),
      .msb_side_i   (msb_side_i),
      .buf_rst_i    (buf_rst_i),
      .s_valid_i    (s_valid_i[n]),
      .s_left_i     (s_left_i[n*SAMPLE_W +: SAMPLE_W]),
      .s_right_i    (s_right_i[n*SAMPLE_W +: SAMPLE_W]),
      .s_ready_o    (s_ready_o[n]),
      .sdata_o      (sdata_o[n]),
      .run_o        (run_o[n]),
      .underrun_o   (underrun_o[n])
    );
  end

  // R6
  lanes_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o[0]) |-> $fell(wclk_o));
endmodule

// File: tb/aud_tx_tb.sv
module aud_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int SW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mck0_tick = 1'b1, mck1_tick = 1'b0, mck_sel = 1'b0;
  logic [3:0] div_code = 4'd1;
  logic [1:0] width_code = 2'd0;
  logic msb_side = 1'b0;
  logic [NL-1:0] lane_en = '0, s_valid = '0;
  logic buf_rst = 1'b0;
  logic [NL*SW-1:0] s_left = '0, s_right = '0;
  logic [NL-1:0] s_ready, sdata, run, underrun;
  logic bclk, wclk;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mck0_tick_i(mck0_tick), .mck1_tick_i(mck1_tick),
    .mck_sel_i(mck_sel), .div_code_i(div_code), .width_code_i(width_code),
    .msb_side_i(msb_side), .lane_en_i(lane_en), .buf_rst_i(buf_rst),
    .s_valid_i(s_valid), .s_left_i(s_left), .s_right_i(s_right), .s_ready_o(s_ready),
    .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sdata), .run_o(run), .underrun_o(underrun)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int tdiv = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // master clock 1: one tick every third cycle
  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    mck1_tick = (tdiv == 0);
  end

  // frame monitor
  logic [63:0] cap [NL][32];
  int ncap [NL];
  logic [63:0] acc [NL];
  logic [NL-1:0] frun = '0, prev_run = '0;
  bit prev_bclk = 0, prev_wclk = 0, last_ws = 0, armed = 0;
  int bitpos = 0, wclk_err = 0, idle_err = 0, align_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk && !prev_bclk) begin
        if (!wclk && last_ws) begin bitpos = 0; armed = 1; end
        if (armed) begin
          if (bitpos == 0) frun = run;
          if (wclk != (bitpos >= 32)) wclk_err++;
          for (int l = 0; l < NL; l++) acc[l] = {acc[l][62:0], sdata[l]};
          bitpos++;
          if (bitpos == 64) begin
            for (int l = 0; l < NL; l++)
              if (frun[l] && ncap[l] < 32) begin cap[l][ncap[l]] = acc[l]; ncap[l]++; end
            armed = 0;
          end
        end
        last_ws = wclk;
      end
      for (int l = 0; l < NL; l++) begin
        if (!run[l] && sdata[l]) idle_err++;
        if (run[l] != prev_run[l] && !(!wclk && prev_wclk)) align_err++;
      end
      prev_bclk = bclk; prev_wclk = wclk; prev_run = run;
    end
  end

  function automatic logic [31:0] slot_of(input logic [1:0] w, input logic m, input logic [23:0] s);
    int wd;
    logic [31:0] v;
    wd = (w == 2'd2) ? 20 : (w == 2'd3) ? 24 : 16;
    v = 32'(s) & ((32'd1 << wd) - 32'd1);
    if (wd == 16 || m) v = v << (32 - wd);
    return v;
  endfunction

  logic [23:0] exp_l [NL][8], exp_r [NL][8];

  task automatic push_pair(input int l, input int k);
    @(negedge clk);
    while (!s_ready[l]) @(negedge clk);
    s_valid[l] = 1'b1;
    s_left[l*SW +: SW] = exp_l[l][k];
    s_right[l*SW +: SW] = exp_r[l][k];
    @(negedge clk);
    s_valid[l] = 1'b0;
  endtask

  task automatic pulse_buf_rst();
    @(negedge clk); buf_rst = 1'b1;
    @(negedge clk); buf_rst = 1'b0;
  endtask

  task automatic clear_caps();
    for (int l = 0; l < NL; l++) ncap[l] = 0;
  endtask

  task automatic wait_caps(input int l, input int n);
    while (ncap[l] < n) @(negedge clk);
  endtask

  task automatic measure(output int p);
    int rises, t0;
    bit pb;
    rises = 0; t0 = 0; p = 0; pb = bclk;
    while (rises < 5) begin
      @(negedge clk);
      if (bclk && !pb) begin
        rises++;
        if (rises == 4) t0 = cyc;
        if (rises == 5) p = cyc - t0;
      end
      pb = bclk;
    end
  endtask

  initial begin
    int p;
    logic [1:0] wl [6];
    logic       ml [6];
    void'($urandom(32'd4242));
    for (int l = 0; l < NL; l++) begin ncap[l] = 0; acc[l] = '0; end
    wl = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
    ml = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    repeat (3) @(negedge clk);
    // reset state
    chk(bclk == 0 && wclk == 0, "R3 reset clocks", {bclk, wclk}, 0);
    chk(run == 0 && sdata == 0, "R7 reset lanes", {run, sdata}, 0);
    chk(underrun == 0 && s_ready == '1, "R10 reset queues", {underrun, s_ready}, {4'h0, 4'hf});
    rst_n = 1'b1;

    // R1 divide ratios on master clock 0 (tick every cycle)
    div_code = 4'd1; measure(p); chk(p == 2,  "R1 code1", p, 2);
    div_code = 4'd2; measure(p); chk(p == 4,  "R1 code2", p, 4);
    div_code = 4'd4; measure(p); chk(p == 8,  "R1 code4", p, 8);
    div_code = 4'd6; measure(p); chk(p == 12, "R1 code6", p, 12);
    div_code = 4'd3; measure(p); chk(p == 2,  "R1 unlisted code", p, 2);
    // R2 master clock 1 (tick every 3 cycles)
    mck_sel = 1'b1; div_code = 4'd2; measure(p); chk(p == 12, "R2 mck1 select", p, 12);
    mck_sel = 1'b0; div_code = 4'd1; measure(p); chk(p == 2, "R2 mck0 select", p, 2);

    // R4 R5 R10 R8 format sweep, all lanes
    for (int c = 0; c < 6; c++) begin
      width_code = wl[c]; msb_side = ml[c];
      pulse_buf_rst();
      clear_caps();
      for (int l = 0; l < NL; l++)
        for (int k = 0; k < 4; k++) begin
          exp_l[l][k] = 24'($urandom); exp_r[l][k] = 24'($urandom);
          push_pair(l, k);
        end
      chk(s_ready == '0, "R10 ready low when full", s_ready, 0);
      // offer a fifth pair on lane 0: must be dropped
      @(negedge clk); s_valid[0] = 1'b1; s_left[0 +: SW] = 24'hFFFFFF; s_right[0 +: SW] = 24'hFFFFFF;
      @(negedge clk); s_valid[0] = 1'b0;
      lane_en = '1;
      for (int l = 0; l < NL; l++) wait_caps(l, 5);
      for (int l = 0; l < NL; l++) begin
        for (int k = 0; k < 4; k++) begin
          logic [63:0] e;
          e = {slot_of(wl[c], ml[c], exp_l[l][k]), slot_of(wl[c], ml[c], exp_r[l][k])};
          chk(cap[l][k] == e, (wl[c] < 2) ? "R4 16-bit slot" : "R5 wide slot", cap[l][k], e);
        end
        chk(cap[l][4] == 0, "R8 R10 silent frame after drain", cap[l][4], 0);
      end
      chk(underrun == '1, "R8 underrun set", underrun, 4'hf);
      lane_en = '0;
      while (run != 0) @(negedge clk);
      chk(underrun == '1, "R8 underrun sticky", underrun, 4'hf);
    end

    // R9 flush: queue two pairs on lane 1, reset buffers, then run
    width_code = 2'd3; msb_side = 1'b0;
    for (int k = 0; k < 2; k++) begin
      exp_l[1][k] = 24'($urandom); exp_r[1][k] = 24'($urandom); push_pair(1, k);
    end
    pulse_buf_rst();
    @(negedge clk);
    chk(underrun == 0, "R9 underrun cleared", underrun, 0);
    clear_caps();
    lane_en = 4'b0010;
    wait_caps(1, 1);
    chk(cap[1][0] == 0, "R9 flushed pairs not sent", cap[1][0], 0);
    chk(underrun[1] == 1, "R9 empty after flush", underrun, 4'h2);
    lane_en = '0;
    while (run != 0) @(negedge clk);

    // R6 R7 late enable on lane 3 while lane 0 runs
    pulse_buf_rst();
    clear_caps();
    for (int k = 0; k < 4; k++) begin
      exp_l[0][k] = 24'($urandom); exp_r[0][k] = 24'($urandom); push_pair(0, k);
      exp_l[3][k] = 24'($urandom); exp_r[3][k] = 24'($urandom); push_pair(3, k);
    end
    lane_en = 4'b0001;
    wait_caps(0, 1);
    repeat (20 + ($urandom % 60)) @(negedge clk);
    lane_en = 4'b1001;
    @(negedge clk);
    chk(run[3] == 0, "R7 run lags enable", run, 4'h1);
    wait_caps(3, 2);
    chk(cap[3][0] == {slot_of(2'd3, 1'b0, exp_l[3][0]), slot_of(2'd3, 1'b0, exp_r[3][0])},
        "R6 late lane full first frame", cap[3][0],
        {slot_of(2'd3, 1'b0, exp_l[3][0]), slot_of(2'd3, 1'b0, exp_r[3][0])});
    repeat (30) @(negedge clk);
    lane_en = 4'b1000;
    @(negedge clk);
    chk(run[0] == 1, "R7 run held until frame end", run, 4'h9);
    lane_en = '0;
    while (run != 0) @(negedge clk);

    chk(align_err == 0, "R6 R7 run edges on frame boundary", align_err, 0);
    chk(idle_err == 0, "R7 idle lane quiet", idle_err, 0);
    chk(wclk_err == 0, "R3 word clock per slot", wclk_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule